// File: doc/BRIEF.md
# Toggle-Bit Load-Completion Poller

This block sits on the host side of a memory bus. It decides when a memory device has finished an internal load into one of its buffers. After the host issues a load command, a start pulse arms the poller. The poller first waits a fixed settle interval, which it derives from the clock period. It then reads one address inside the chosen buffer's window twice in a row and compares bit 6 of the two words. If the bit changed between the two reads, the device is still loading and another pair of reads follows. If the bit held, the load is complete.

A cold-reset mode always polls the boot buffer window. The host uses this mode when no interrupt line can be trusted, for example while the boot-code copy is still running. A limit on the number of failed pairs ends a poll that never settles. The poller refuses to start, and aborts any poll in flight, while the device is in a synchronous or cached read mode, because the toggle bit has no meaning in those modes. Read data is taken one cycle after each read strobe. Bus timing beyond that is outside this block.

Top module: `tbit_poller`

## Requirements
- R1: After reset, rd_strobe_o, done_o, timeout_o, error_o and rd_addr_o are all zero.
- R2: An accepted start is followed by exactly S = ceil(SETTLE_PS / CLK_PS) cycles without a read strobe. The first strobe is high in the cycle that begins S clock edges after the start edge (S = 35 by default).
- R3: The poll address is latched at start as base + offset_i, with a 4-bit offset. The base is 0x000 for target code 0 (boot), 0x200 for code 1 (data buffer 0) and 0x600 for code 2 (data buffer 1). The address stays unchanged for every read of the poll.
- R4: With cold_mode_i high at start, the boot window (base 0x000) is used whatever target_i holds, including code 3.
- R5: Reads come in pairs on two consecutive strobe cycles, with data sampled one cycle after each strobe. Only bit 6 is compared; all other data bits have no effect. When bit 6 is equal in a pair, done_o pulses for one cycle, 3k cycles after the first strobe of a poll that needs k pairs. The block is then idle with no further strobes.
- R6: Each pair whose bit 6 differs counts as a miss and starts a new pair. When the miss count reaches max_polls_i (latched at start; a value of 0 acts as 1), timeout_o pulses for one cycle in place of done_o and the block goes idle.
- R7: A start while idle with sync_mode_i high, or with target code 3 and cold_mode_i low, is refused. error_o pulses on the next edge and no strobe follows.
- R8: sync_mode_i high in any active cycle aborts the poll. error_o pulses on the next edge, and it takes priority over a done or timeout that would fall on the same edge.
- R9: A start pulse while a poll is active is ignored. Address, timing and outcome stay unchanged.
- R10: done_o, timeout_o and error_o are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, issued after the load command |
| target_i | input | 2 | Buffer code: 0 boot, 1 data 0, 2 data 1, 3 invalid |
| offset_i | input | OFF_W | Word offset inside the buffer window |
| cold_mode_i | input | 1 | Cold-reset mode: poll the boot window |
| sync_mode_i | input | 1 | Synchronous or cached read mode active |
| max_polls_i | input | POLL_W | Number of failed pairs allowed before timeout |
| rd_data_i | input | DATA_W | Read data, valid one cycle after a strobe |
| rd_addr_o | output | ADDR_W | Poll read address |
| rd_strobe_o | output | 1 | Read strobe |
| done_o | output | 1 | Load complete pulse |
| timeout_o | output | 1 | Miss limit reached pulse |
| error_o | output | 1 | Refused or aborted pulse |

## Verification
On one clock edge, the pair-compare step can produce a done while a mode change forces an abort. Both results target the same flag register, so the two functions collide there. The bench runs a poll whose final pair will match and raises sync_mode_i exactly in the compare cycle. It expects error_o on the next edge and no done_o at all. A second directed case aborts during the settle wait, where only the error path can act, and separates the abort's timing from that collision.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  typedef enum logic [1:0] {
    BUF_BOOT  = 2'd0,
    BUF_DATA0 = 2'd1,
    BUF_DATA1 = 2'd2,
    BUF_RSVD  = 2'd3
  } buf_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_RD1,
    ST_RD2,
    ST_CMP
  } poll_st_e;

  localparam int unsigned STATUS_BIT = 6;

  // Whole clock cycles that cover a wait given in picoseconds (at least one).
  function automatic int unsigned settle_cycles(int unsigned wait_ps, int unsigned clk_ps);
    int unsigned c;
    c = (wait_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  // First word of each buffer window.
  function automatic int unsigned window_base(buf_sel_e sel);
    case (sel)
      BUF_DATA0: return 32'h200;
      BUF_DATA1: return 32'h600;
      default:   return 32'h000;
    endcase
  endfunction

  // The buffer actually polled once cold mode has been applied.
  function automatic buf_sel_e effective_sel(logic cold, logic [1:0] code);
    return cold ? BUF_BOOT : buf_sel_e'(code);
  endfunction

endpackage

// File: rtl/tbp_settle_timer.sv
module tbp_settle_timer #(
  parameter int unsigned CYCLES = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load_i)               cnt_q <= CW'(CYCLES - 1);
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == '0);

  // R2: the count never rises while the wait is running
  p_settle_monotonic_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q < $past(cnt_q)) || $past(load_i));

endmodule

// File: rtl/tbp_poll_budget.sv
module tbp_poll_budget #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         miss_i,
  input  logic [W-1:0] limit_i,
  output logic         exhaust_o
);
  logic [W-1:0] misses_q;
  logic [W:0]   next_cnt;

  assign next_cnt  = {1'b0, misses_q} + (W+1)'(1);
  assign exhaust_o = miss_i && (next_cnt >= {1'b0, limit_i});

  always_ff @(posedge clk) begin
    if (!rst_n)                     misses_q <= '0;
    else if (clear_i)               misses_q <= '0;
    else if (miss_i && !exhaust_o)  misses_q <= next_cnt[W-1:0];
  end

  // R6: the stored miss count stays below the effective limit
  p_miss_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i == '0) ? (misses_q == '0) : (misses_q < limit_i));

endmodule

// File: rtl/tbp_toggle_cmp.sv
module tbp_toggle_cmp (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_first_i,
  input  logic status_i,
  output logic match_o
);
  logic first_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           first_q <= 1'b0;
    else if (cap_first_i) first_q <= status_i;
  end

  assign match_o = (first_q == status_i);

endmodule

// File: rtl/tbit_poller.sv
module tbit_poller
  import tbp_pkg::*;
#(
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned SETTLE_PS = 350000,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned POLL_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        target_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              cold_mode_i,
  input  logic              sync_mode_i,
  input  logic [POLL_W-1:0] max_polls_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_strobe_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              error_o
);
  localparam int unsigned SETTLE_N = settle_cycles(SETTLE_PS, CLK_PS);
  localparam int unsigned SCW      = $clog2(SETTLE_N + 1);

  poll_st_e          state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [POLL_W-1:0] limit_q;
  logic              done_q, timeout_q, error_q;
  logic [SCW-1:0]    since_q;
  logic              active_q;

  // Named internal events
  logic     idle, accept, refuse, go, abort;
  logic     settle_expire, pair_match, budget_exhaust;
  logic     cmp_ok, cmp_hit, cmp_miss;
  buf_sel_e eff_sel;
  logic [ADDR_W-1:0] poll_addr;
  logic     unused_data;

  assign unused_data = ^rd_data_i;

  assign idle      = (state_q == ST_IDLE);
  assign eff_sel   = effective_sel(cold_mode_i, target_i);
  assign poll_addr = ADDR_W'(window_base(eff_sel) + 32'(offset_i));
  assign accept    = start_i && idle;
  assign refuse    = accept && (sync_mode_i || eff_sel == BUF_RSVD);
  assign go        = accept && !refuse;
  assign abort     = !idle && sync_mode_i;
  assign cmp_ok    = (state_q == ST_CMP) && !abort;
  assign cmp_hit   = cmp_ok && pair_match;
  assign cmp_miss  = cmp_ok && !pair_match;

  tbp_settle_timer #(.CYCLES(SETTLE_N)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (go),
    .run_i   (state_q == ST_SETTLE),
    .expire_o(settle_expire)
  );

  tbp_toggle_cmp u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_first_i(state_q == ST_RD2),
    .status_i   (rd_data_i[STATUS_BIT]),
    .match_o    (pair_match)
  );

  tbp_poll_budget #(.W(POLL_W)) u_budget (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (go),
    .miss_i   (cmp_miss),
    .limit_i  (limit_q),
    .exhaust_o(budget_exhaust)
  );

  always_comb begin
    state_d = state_q;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:   if (go) state_d = ST_SETTLE;
        ST_SETTLE: if (settle_expire) state_d = ST_RD1;
        ST_RD1:    state_d = ST_RD2;
        ST_RD2:    state_d = ST_CMP;
        ST_CMP:    state_d = (pair_match || budget_exhaust) ? ST_IDLE : ST_RD1;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      limit_q   <= '0;
      done_q    <= 1'b0;
      timeout_q <= 1'b0;
      error_q   <= 1'b0;
      since_q   <= SCW'(SETTLE_N);
      active_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      done_q    <= cmp_hit;
      timeout_q <= cmp_miss && budget_exhaust;
      error_q   <= refuse || abort;
      active_q  <= !idle;
      if (go) begin
        addr_q  <= poll_addr;
        limit_q <= max_polls_i;
        since_q <= '0;
      end else if (since_q != SCW'(SETTLE_N)) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  assign rd_addr_o   = addr_q;
  assign rd_strobe_o = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign done_o      = done_q;
  assign timeout_o   = timeout_q;
  assign error_o     = error_q;

  // R2: no strobe inside the settle window after an accepted start
  p_no_early_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_o |-> (since_q >= SCW'(SETTLE_N)));

  // R3: address held through an active poll
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && active_q) |-> $stable(rd_addr_o));

  // R5: a strobe that begins is followed by its partner unless aborted
  p_pair_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rd_strobe_o) && !sync_mode_i) |=> rd_strobe_o);

  // R6: a timeout only follows an exhausted budget
  p_timeout_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_miss && budget_exhaust) |=> (timeout_o && idle));

  // R7: a refused start leaves the block idle with an error
  p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sync_mode_i) |=> (error_o && idle && !rd_strobe_o));

  // R8: abort beats done in the compare cycle
  p_abort_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CMP) && sync_mode_i) |=> (error_o && !done_o));

  // R9: a start during the read phase does not disturb the sequence
  p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RD1) && start_i && !sync_mode_i) |=> (state_q == ST_RD2));

  // R10: result flags are exclusive pulses
  p_flags_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, timeout_o, error_o}));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: tb/tbit_poller_test.sv
module tbit_poller_test;
  localparam int CLK_NS = 10;
  localparam int S_EXP  = (350 + CLK_NS - 1) / CLK_NS;
  localparam int HANG   = S_EXP + 3 * 300;

  localparam int K_DONE = 1, K_TMO = 2, K_ERR = 3, K_HUNG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  target = 2'd0;
  logic [3:0]  offset = 4'd0;
  logic        cold = 1'b0;
  logic        sync = 1'b0;
  logic [7:0]  max_polls = 8'd0;
  logic [15:0] rd_data = 16'd0;
  logic [15:0] rd_addr;
  logic        rd_strobe, done, timeout, error;

  int tests = 0;
  int fails = 0;
  int busy_left = 0;
  logic tog = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  tbit_poller #(.CLK_PS(CLK_NS * 1000), .SETTLE_PS(350000)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .target_i(target),
    .offset_i(offset), .cold_mode_i(cold), .sync_mode_i(sync),
    .max_polls_i(max_polls), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .rd_strobe_o(rd_strobe), .done_o(done), .timeout_o(timeout), .error_o(error)
  );

  // Device model: while loading, every read flips bit 6; other bits are noise.
  always @(posedge clk) begin
    if (rd_strobe) begin
      logic nb;
      nb = (busy_left > 0) ? ~tog : tog;
      if (busy_left > 0) busy_left <= busy_left - 1;
      tog     <= nb;
      rd_data <= ($urandom() & 16'hFFBF) | (16'(nb) << 6);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_base(input bit c, input logic [1:0] t);
    if (c || t == 2'd0) return 0;
    return (t == 2'd1) ? 'h200 : 'h600;
  endfunction

  // Pairs needed before bit 6 is seen equal, for a load that flips it busy reads times.
  function automatic int pairs_needed(input int busy);
    for (int p = 0; p < 1000; p++) begin
      int a, b;
      a = ((2*p + 1) < busy ? (2*p + 1) : busy) & 1;
      b = ((2*p + 2) < busy ? (2*p + 2) : busy) & 1;
      if (a == b) return p + 1;
    end
    return 1000;
  endfunction

  task automatic run_case(input bit c, input logic [1:0] t, input logic [3:0] off,
                          input logic [7:0] lim, input int busy, input int abort_at,
                          input bit restart_mid, input string req);
    int n, strobes, addr_bad, early, kind, exp_kind, exp_n, exp_str, need, lim_eff;
    logic [15:0] ea;
    ea = 16'(exp_base(c, t) + int'(off));
    @(negedge clk);
    cold = c; target = t; offset = off; max_polls = lim; busy_left = busy; start = 1'b1;
    @(posedge clk);
    n = 0; strobes = 0; addr_bad = 0; early = 0; kind = 0;
    forever begin
      @(negedge clk);
      if (n == 0) start = 1'b0;
      if (restart_mid && n == S_EXP + 1) begin
        start = 1'b1; target = t + 2'd1; offset = ~off; cold = ~c;
      end
      if (restart_mid && n == S_EXP + 2) start = 1'b0;
      if (rd_strobe) begin
        strobes++;
        if (rd_addr != ea) addr_bad++;
        if (n < S_EXP) early++;
      end
      if (done)         begin kind = K_DONE; break; end
      if (timeout)      begin kind = K_TMO;  break; end
      if (error)        begin kind = K_ERR;  break; end
      if (n == abort_at) sync = 1'b1;
      if (n > HANG)     begin kind = K_HUNG; break; end
      @(posedge clk);
      n++;
    end
    sync = 1'b0;
    start = 1'b0;
    need    = pairs_needed(busy);
    lim_eff = (lim == 0) ? 1 : int'(lim);
    if (abort_at >= 0) begin
      exp_kind = K_ERR; exp_n = abort_at + 1;
      exp_str  = (abort_at + 1 >= S_EXP) ? 2 * ((abort_at + 1 - S_EXP) / 3) : 0;
    end else if (need - 1 >= lim_eff) begin
      exp_kind = K_TMO; exp_n = S_EXP + 3 * lim_eff; exp_str = 2 * lim_eff;
    end else begin
      exp_kind = K_DONE; exp_n = S_EXP + 3 * need; exp_str = 2 * need;
    end
    chk(kind == exp_kind, req, "outcome (R5/R6/R8)", kind, exp_kind);
    chk(n == exp_n, req, "outcome cycle (R2/R5)", n, exp_n);
    chk(strobes == exp_str, req, "strobe count (R5)", strobes, exp_str);
    chk(addr_bad == 0, req, "address (R3/R4)", addr_bad, 0);
    chk(early == 0, req, "early strobe (R2)", early, 0);
    begin
      int extra;
      extra = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (rd_strobe || done || timeout || error) extra++;
      end
      chk(extra == 0, req, "quiet after result (R10)", extra, 0);
    end
    busy_left = 0;
  endtask

  task automatic refuse_case(input bit s, input logic [1:0] t, input string req);
    int bad;
    @(negedge clk);
    cold = 1'b0; sync = s; target = t; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; sync = 1'b0;
    chk(error == 1'b1, req, "error on refused start (R7)", error, 1);
    bad = 0;
    for (int i = 0; i < S_EXP + 10; i++) begin
      @(negedge clk);
      if (rd_strobe || done || timeout || error) bad++;
    end
    chk(bad == 0, req, "no activity after refusal (R7)", bad, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rd_strobe == 0 && done == 0 && timeout == 0 && error == 0 && rd_addr == 0,
        "R1", "reset outputs", {rd_strobe, done, timeout, error}, 0);
    rst_n = 1'b1;

    // Directed cases
    run_case(1'b0, 2'd0, 4'hF, 8'd4, 0, -1, 1'b0, "R5_boot_idle");
    run_case(1'b0, 2'd1, 4'h3, 8'd8, 5, -1, 1'b0, "R3_data0");
    run_case(1'b0, 2'd2, 4'hA, 8'd8, 6, -1, 1'b0, "R3_data1");
    run_case(1'b1, 2'd3, 4'h7, 8'd8, 3, -1, 1'b0, "R4_cold_code3");
    run_case(1'b1, 2'd2, 4'h1, 8'd8, 2, -1, 1'b0, "R4_cold_data1");
    run_case(1'b0, 2'd1, 4'h0, 8'd2, 20, -1, 1'b0, "R6_timeout");
    run_case(1'b0, 2'd0, 4'h0, 8'd0, 9, -1, 1'b0, "R6_limit_zero");
    run_case(1'b0, 2'd2, 4'h4, 8'd8, 4, -1, 1'b1, "R9_restart");
    run_case(1'b0, 2'd1, 4'h2, 8'd8, 4, 10, 1'b0, "R8_abort_settle");
    // Collision: abort lands in the compare cycle of the matching pair
    run_case(1'b0, 2'd1, 4'h2, 8'd8, 4, S_EXP + 3 * pairs_needed(4) - 1, 1'b0, "R8_abort_vs_done");
    refuse_case(1'b1, 2'd0, "R7_sync");
    refuse_case(1'b0, 2'd3, "R7_code3");

    // Constrained random
    for (int k = 0; k < 24; k++) begin
      logic [1:0] t;
      t = 2'($urandom_range(0, 2));
      run_case(($urandom_range(0, 3) == 0), t, 4'($urandom_range(0, 15)),
               8'($urandom_range(0, 8)), int'($urandom_range(0, 14)), -1, 1'b0, "R5_random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule